// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power-mode state of a processor subsystem. It keeps one normal operating mode, split into a high-frequency and a low-frequency sub-state, and four reduced-power modes: doze, sleep, deep-sleep and power-down. Software programs it through a small write port. The port carries a mode field, a lock bit that guards mode entry, a clock-select bit that picks the high or low sub-state, and two divider fields, one for each sub-state.

A reduced-power mode is entered only by a mode-field write. The write must be made from the normal mode, while the processor's power-enable input is high and the lock bit is clear. A wake event returns the block to normal-high from any state. The block drives the current mode, the divider value of the active sub-state, and clock-enable levels for the core domain and the timebase domain. The dividing, the analog switching and the generation of wake events are done elsewhere. The interface carries no data stream, so every pin is a plain level or a single-cycle strobe with no back-pressure.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the mode is normal (code 0), the sub-state is high (`low_freq_o`=0), the lock bit is set, the high divider is `RST_DIV_HI`, the low divider is `RST_DIV_LO`, and both clock enables are 1.
- R2: Mode codes are 0 normal, 1 doze, 2 sleep, 3 deep-sleep, 4 power-down. A mode write carrying code 5, 6 or 7 leaves the mode unchanged, and `mode_o` never shows a value above 4.
- R3: A mode write (`wr_addr`=0, code in `wr_data[2:0]`) is accepted only when `pow_en_i`=1, the lock bit is 0 and the current mode is normal. Otherwise the mode is unchanged.
- R4: `mode_o` shows an accepted mode write on the first clock edge after the write cycle.
- R5: While in doze, mode writes and clock-select writes are ignored.
- R6: `wake_i` high at a clock edge sets the mode to normal and the sub-state to high. It overrides any write in the same cycle.
- R7: `div_o` equals the high divider when `low_freq_o`=0 and the low divider when `low_freq_o`=1. Writes to address 3 (high divider) and address 4 (low divider) take the full `wr_data` in any mode.
- R8: `core_clk_en_o` is 0 in sleep, deep-sleep and power-down, and 1 in normal and doze. `tb_clk_en_o` is 0 only in power-down.
- R9: The lock bit (address 1, `wr_data[0]`) can be written in every mode. The clock-select bit (address 2, `wr_data[0]`, 1 = low) can be written in every mode except doze. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 3 | Field select: 0 mode, 1 lock, 2 clock select, 3 high divider, 4 low divider |
| wr_data | input | DIV_W | Write value |
| pow_en_i | input | 1 | Processor power-enable level |
| wake_i | input | 1 | Low-power exit event |
| mode_o | output | 3 | Current mode code |
| low_freq_o | output | 1 | 1 when the low-frequency sub-state is active |
| div_o | output | DIV_W | Divider value of the active sub-state |
| core_clk_en_o | output | 1 | Core clock domain enable |
| tb_clk_en_o | output | 1 | Timebase clock domain enable |

## Verification
Directed sequences separate the three conditions that block entry: a write while locked, a write with power-enable low, and a write made from outside normal. Each of these must leave the mode unchanged, while a fully permitted write must change it one edge later. Further directed cases put a mode write and a clock-select write into doze, which tells freezing apart from acceptance, and raise a wake in the same cycle as a write, which shows which of the two wins. Constrained-random traffic mixes all addresses, illegal mode codes, frequent wakes and toggling power-enable. This reaches every mode with both sub-states and both divider values active, and each cycle is compared with a bench model.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_DOZE   = 3'd1,
    MODE_SLEEP  = 3'd2,
    MODE_DEEP   = 3'd3,
    MODE_PDOWN  = 3'd4
  } lpm_mode_e;

  localparam int ADDR_W       = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOCK   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CLKSEL = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_DIV_HI = 3'd3;
  localparam int NUM_DIV      = 2;
endpackage

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter logic [DIV_W-1:0] RST_DIV_HI = 1,
  parameter logic [DIV_W-1:0] RST_DIV_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DIV_W-1:0]  wr_data,
  input  logic              wake,
  input  logic              in_doze,
  output logic              lock_q,
  output logic              low_q,
  output logic [DIV_W-1:0]  div_hi_q,
  output logic [DIV_W-1:0]  div_lo_q
);
  logic [DIV_W-1:0] div_q [NUM_DIV];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else if (wr_en && wr_addr == ADDR_LOCK) lock_q <= wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else if (wake) low_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_CLKSEL && !in_doze) low_q <= wr_data[0];
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_DIV_HI + ADDR_W'(g);
    localparam logic [DIV_W-1:0]  MY_RST  = (g == 0) ? RST_DIV_HI : RST_DIV_LO;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q[g] <= MY_RST;
      else if (wr_en && wr_addr == MY_ADDR) div_q[g] <= wr_data;
    end
  end

  assign div_hi_q = div_q[0];
  assign div_lo_q = div_q[1];
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_code,
  input  logic       pow_en,
  input  logic       lock,
  input  logic       wake,
  output lpm_mode_e  mode_q
);
  logic code_legal;
  logic permit;
  lpm_mode_e mode_d;

  assign code_legal = (mode_code <= 3'(MODE_PDOWN));
  assign permit     = pow_en && !lock && (mode_q == MODE_NORMAL);

  always_comb begin
    mode_d = mode_q;
    if (wake) mode_d = MODE_NORMAL;
    else if (mode_wr && permit && code_legal) mode_d = lpm_mode_e'(mode_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_NORMAL;
    else mode_q <= mode_d;
  end
endmodule

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  lpm_mode_e        mode,
  input  logic             low,
  input  logic [DIV_W-1:0] div_hi,
  input  logic [DIV_W-1:0] div_lo,
  output logic [DIV_W-1:0] div_o,
  output logic             core_en,
  output logic             tb_en
);
  always_comb begin
    core_en = 1'b1;
    tb_en   = 1'b1;
    unique case (mode)
      MODE_NORMAL, MODE_DOZE: ;
      MODE_SLEEP, MODE_DEEP: core_en = 1'b0;
      MODE_PDOWN: begin
        core_en = 1'b0;
        tb_en   = 1'b0;
      end
      default: ;
    endcase
  end

  assign div_o = low ? div_lo : div_hi;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter logic [DIV_W-1:0] RST_DIV_HI = 1,
  parameter logic [DIV_W-1:0] RST_DIV_LO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             pow_en_i,
  input  logic             wake_i,
  output logic [2:0]       mode_o,
  output logic             low_freq_o,
  output logic [DIV_W-1:0] div_o,
  output logic             core_clk_en_o,
  output logic             tb_clk_en_o
);
  lpm_mode_e        mode_q;
  logic             lock_q;
  logic             low_q;
  logic [DIV_W-1:0] div_hi_q;
  logic [DIV_W-1:0] div_lo_q;
  logic             in_doze;
  logic             mode_wr;

  assign in_doze = (mode_q == MODE_DOZE);
  assign mode_wr = wr_en && (wr_addr == ADDR_MODE) && !in_doze;

  lpm_regs #(.DIV_W(DIV_W), .RST_DIV_HI(RST_DIV_HI), .RST_DIV_LO(RST_DIV_LO)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wake(wake_i), .in_doze(in_doze), .lock_q(lock_q), .low_q(low_q),
    .div_hi_q(div_hi_q), .div_lo_q(div_lo_q)
  );

  lpm_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(wr_data[2:0]),
    .pow_en(pow_en_i), .lock(lock_q), .wake(wake_i), .mode_q(mode_q)
  );

  lpm_clk_gate #(.DIV_W(DIV_W)) u_gate (
    .mode(mode_q), .low(low_q), .div_hi(div_hi_q), .div_lo(div_lo_q),
    .div_o(div_o), .core_en(core_clk_en_o), .tb_en(tb_clk_en_o)
  );

  assign mode_o     = mode_q;
  assign low_freq_o = low_q;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       pow_en_i,
  input logic       wake_i,
  input logic       lock_q,
  input logic [2:0] mode_o,
  input logic       low_freq_o,
  input logic       core_clk_en_o,
  input logic       tb_clk_en_o
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4);  // R2
  AST_NO_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd0 && !wake_i && (!pow_en_i || lock_q)) |=> mode_o == 3'd0);  // R3
  AST_DOZE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd1 && !wake_i) |=> (mode_o == 3'd1 && $stable(low_freq_o)));  // R5
  AST_EXIT_NORMAL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wake_i |=> (mode_o == 3'd0 && !low_freq_o));  // R6
  AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o >= 3'd2) |-> !core_clk_en_o);  // R8
  AST_TB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tb_clk_en_o == (mode_o != 3'd4));  // R8
  AST_ODD_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 3'd5 && !wake_i) |=> ($stable(low_freq_o) && $stable(mode_o)));  // R9
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .pow_en_i(pow_en_i),
  .wake_i(wake_i), .lock_q(lock_q), .mode_o(mode_o), .low_freq_o(low_freq_o),
  .core_clk_en_o(core_clk_en_o), .tb_clk_en_o(tb_clk_en_o)
);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int DIV_W = 4;
  localparam logic [DIV_W-1:0] RHI = 1;
  localparam logic [DIV_W-1:0] RLO = 8;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, pow_en_i = 0, wake_i = 0;
  logic [2:0] wr_addr = 0;
  logic [DIV_W-1:0] wr_data = 0;
  logic [2:0] mode_o;
  logic low_freq_o, core_clk_en_o, tb_clk_en_o;
  logic [DIV_W-1:0] div_o;

  int checks = 0, errors = 0;
  logic [2:0] m_mode;
  logic m_lock, m_low;
  logic [DIV_W-1:0] m_hi, m_lo;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.DIV_W(DIV_W), .RST_DIV_HI(RHI), .RST_DIV_LO(RLO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pow_en_i(pow_en_i), .wake_i(wake_i), .mode_o(mode_o), .low_freq_o(low_freq_o),
    .div_o(div_o), .core_clk_en_o(core_clk_en_o), .tb_clk_en_o(tb_clk_en_o)
  );

  function automatic logic exp_core(input logic [2:0] m);
    return m <= 3'd1;
  endfunction
  function automatic logic exp_tb(input logic [2:0] m);
    return m != 3'd4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R4 mode", mode_o, m_mode);
    chk("R9 low_freq", low_freq_o, m_low);
    chk("R7 div", div_o, m_low ? m_lo : m_hi);
    chk("R8 core_en", core_clk_en_o, exp_core(m_mode));
    chk("R8 tb_en", tb_clk_en_o, exp_tb(m_mode));
  endtask

  // Model step: uses the state before the edge, as the requirements state it
  task automatic step(input logic we, input logic [2:0] a, input logic [DIV_W-1:0] d,
                      input logic pw, input logic wk);
    logic [2:0] nm;
    logic nl, nk;
    logic [DIV_W-1:0] nh, nlo;
    wr_en = we; wr_addr = a; wr_data = d; pow_en_i = pw; wake_i = wk;
    nm = m_mode; nl = m_low; nk = m_lock; nh = m_hi; nlo = m_lo;
    if (wk) begin
      nm = 3'd0; nl = 1'b0;
    end else if (we) begin
      if (a == 3'd0 && m_mode == 3'd0 && pw && !m_lock && d[2:0] <= 3'd4) nm = d[2:0];
      if (a == 3'd2 && m_mode != 3'd1) nl = d[0];
    end
    if (we && a == 3'd1) nk = d[0];
    if (we && a == 3'd3) nh = d;
    if (we && a == 3'd4) nlo = d;
    m_mode = nm; m_low = nl; m_lock = nk; m_hi = nh; m_lo = nlo;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_mode = 0; m_lock = 1; m_low = 0; m_hi = RHI; m_lo = RLO;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 low_freq", low_freq_o, 0);
    chk("R1 div", div_o, RHI);
    chk("R1 core_en", core_clk_en_o, 1);
    chk("R1 tb_en", tb_clk_en_o, 1);
    // R3: locked at reset, write sleep is refused
    step(1, 3'd0, 4'd2, 1, 0);
    chk("R3 locked", mode_o, 0);
    step(1, 3'd1, 4'd0, 1, 0);           // unlock (R9)
    step(1, 3'd0, 4'd2, 0, 0);           // power-enable low
    chk("R3 pow_en low", mode_o, 0);
    step(1, 3'd0, 4'd6, 1, 0);           // illegal code
    chk("R2 code 6 ignored", mode_o, 0);
    step(1, 3'd2, 4'd1, 1, 0);           // low sub-state
    chk("R7 low div", div_o, RLO);
    step(1, 3'd0, 4'd1, 1, 0);           // enter doze
    chk("R4 doze next edge", mode_o, 1);
    step(1, 3'd0, 4'd3, 1, 0);
    chk("R5 doze mode frozen", mode_o, 1);
    step(1, 3'd2, 4'd0, 1, 0);
    chk("R5 doze clksel frozen", low_freq_o, 1);
    step(1, 3'd4, 4'd5, 1, 0);           // divider write in doze
    chk("R7 div lo in doze", div_o, 5);
    step(1, 3'd7, 4'd15, 1, 0);
    chk("R9 addr7 quiet", div_o, 5);
    step(1, 3'd0, 4'd4, 1, 1);           // wake beats write
    chk("R6 wake mode", mode_o, 0);
    chk("R6 wake high", low_freq_o, 0);
    step(1, 3'd0, 4'd4, 1, 0);           // power-down
    chk("R8 pdown tb", tb_clk_en_o, 0);
    step(1, 3'd0, 4'd0, 1, 0);           // write from non-normal refused
    chk("R3 not from pdown", mode_o, 4);
    step(1, 3'd2, 4'd1, 1, 1);           // wake beats clksel write
    chk("R6 wake over clksel", low_freq_o, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) a = 3'd0;
      step($urandom_range(0, 3) != 0, a, DIV_W'($urandom),
           $urandom_range(0, 4) != 0, $urandom_range(0, 11) == 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule